// File: doc/BRIEF.md
# AAL5 Cell Segmenter with Trailer Placement

This block turns a byte stream of packet data into 53-byte ATM cells. Every cell starts with a 4-byte header and a computed HEC byte, and then carries 48 payload bytes. In AAL5 mode the block keeps a CRC-32 and a byte count that run across all cells of a packet. At the end of the packet it pads the payload with zeros and writes an 8-byte trailer at the end of the last cell. When the trailer cannot fit after the last data bytes, the block sends one more cell that carries only padding and the trailer. Two transparent modes send zero-padded cells with no CRC and no trailer.

A packet starts when `in_valid` is seen while the block is idle. In that cycle the block samples the header word, the control half-word, the mode and the packet length. It uses the length to decide, before the header of each cell goes out, whether that cell is the final one. In the final cell the block changes the PTI field of the header. The output is byte serial with no backpressure. `out_sop` marks the first header byte of each cell.

Top module: `aal5_segmenter`

## Requirements
- R1: Each cell is exactly 53 output bytes in this order: 4 header bytes, 1 HEC byte, 48 payload bytes. `out_sop` is high with `out_valid` on the first header byte and low on every other byte.
- R2: The HEC byte is a CRC-8 over the 4 header bytes as they are sent. It uses polynomial 0x07, starts from 0, takes the bits MSB first, and the result is XORed with 0x55.
- R3: Data bytes leave in arrival order, one cycle after their handshake. `in_ready` is low while header, HEC, padding or trailer bytes are being produced, and stays low once all `pkt_len` bytes have been taken.
- R4: In AAL5 mode (`mode`=00), if the bytes remaining at the start of a cell number 40 or fewer, that cell is the final one. Its data is followed by zeros up to payload offset 40. Offsets 40..43 hold the control/length word and offsets 44..47 hold the CRC field. Both words are sent MSB first.
- R5: The CRC field is the bit-inverse of a CRC-32. That CRC uses polynomial 0x04C11DB7, starts from all ones at each packet, and takes the bits MSB first. It covers every payload byte of the earlier cells and payload offsets 0..43 of the final cell.
- R6: In AAL5 mode, if the remaining bytes are between 41 and 48, the cell is filled with data and then zeros, and is sent as a non-final cell. The trailer then goes into one more cell made of 40 zero bytes followed by the trailer.
- R7: In the final cell of AAL5 mode and of transparent-with-PTI mode, header bit 3 is cleared and header bit 1 is set (the header word is sent MSB first). All other cells carry the header word unchanged.
- R8: The control/length word is the sampled 16-bit control value in bits 31:16 and, in bits 15:0, the number of data bytes placed into the packet's cells.
- R9: In the transparent modes (`mode`=01 without PTI change, 10 with PTI change, 11 treated as 01), a cell is final when 48 or fewer bytes remain. The last cell is zero-padded. No CRC or trailer is sent.
- R10: During and after reset with no input, `out_valid`, `out_sop` and `in_ready` are low.
- R11: `hdr_word`, `ctl_word`, `mode` and `pkt_len` are sampled only when a packet starts. Changing them later in the packet has no effect on its cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Data byte valid; when idle, also starts a packet |
| in_ready | output | 1 | Block accepts the data byte this cycle |
| in_data | input | 8 | Packet data byte |
| pkt_len | input | LEN_W (16) | Packet length in bytes (at least 1), sampled at packet start |
| hdr_word | input | 8*HDR_BYTES (32) | Cell header word, sampled at packet start |
| ctl_word | input | 16 | Control half of the trailer word, sampled at packet start |
| mode | input | 2 | 00 AAL5, 01 transparent, 10 transparent with PTI, 11 as 01 |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output cell byte |
| out_sop | output | 1 | First header byte of a cell |

## Verification
Two things can happen in the same cycle. The last data byte can arrive in the cycle where the block must decide whether the trailer still fits, and the final data byte can land on payload offset 47 just as the block chooses the next header. Packet lengths of 40, 41, 48 and 88 bytes drive the remaining count to exactly these boundaries, while gaps in `in_valid` shift the timing of each handshake. The bench builds the expected byte stream as a single padded buffer. In that buffer the trailer sits at the very end and the CRC runs over everything before the CRC field. The bench then compares this buffer byte by byte with the captured cells, grouping the results by header, HEC, data, padding, length word and CRC.

// File: rtl/aal5seg_pkg.sv
`timescale 1ns/1ps
package aal5seg_pkg;

   typedef enum logic [1:0] {
      MODE_AAL5     = 2'b00,
      MODE_TR_PLAIN = 2'b01,
      MODE_TR_PTI   = 2'b10,
      MODE_TR_SPARE = 2'b11
   } seg_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_HDR  = 2'b01,
      ST_PAY  = 2'b10
   } seg_state_e;

   // one byte of a CRC-32, MSB first
   function automatic logic [31:0] crc32_byte(input logic [31:0] c,
                                              input logic [7:0]  d,
                                              input logic [31:0] poly);
      logic [31:0] r;
      r = c;
      for (int b = 7; b >= 0; b--) begin
         if (r[31] ^ d[b]) r = {r[30:0], 1'b0} ^ poly;
         else              r = {r[30:0], 1'b0};
      end
      return r;
   endfunction

   // one byte of a CRC-8, MSB first
   function automatic logic [7:0] crc8_byte(input logic [7:0] c,
                                            input logic [7:0] d,
                                            input logic [7:0] poly);
      logic [7:0] r;
      r = c;
      for (int b = 7; b >= 0; b--) begin
         if (r[7] ^ d[b]) r = {r[6:0], 1'b0} ^ poly;
         else             r = {r[6:0], 1'b0};
      end
      return r;
   endfunction

   // byte k of a 32-bit word, k=0 is the most significant
   function automatic logic [7:0] word_byte(input logic [31:0] w,
                                            input logic [1:0]  k);
      case (k)
         2'd0:    return w[31:24];
         2'd1:    return w[23:16];
         2'd2:    return w[15:8];
         default: return w[7:0];
      endcase
   endfunction

endpackage

// File: rtl/aal5seg_crc32.sv
`timescale 1ns/1ps
module aal5seg_crc32 #(
   parameter logic [31:0] POLY = 32'h04C1_1DB7,
   parameter logic [31:0] SEED = 32'hFFFF_FFFF
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        en,
   input  logic [7:0]  din,
   output logic [31:0] crc_q
);
   import aal5seg_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   crc_q <= SEED;
      else if (clr) crc_q <= SEED;
      else if (en)  crc_q <= crc32_byte(crc_q, din, POLY);
   end
endmodule

// File: rtl/aal5seg_hec.sv
`timescale 1ns/1ps
module aal5seg_hec #(
   parameter int          HDR_BYTES = 4,
   parameter logic [7:0]  POLY      = 8'h07,
   parameter logic [7:0]  COSET     = 8'h55
) (
   input  logic [8*HDR_BYTES-1:0] hdr,
   output logic [7:0]             hec
);
   import aal5seg_pkg::*;

   logic [7:0] chain [0:HDR_BYTES];
   assign chain[0] = 8'h00;

   for (genvar g = 0; g < HDR_BYTES; g++) begin : g_step
      assign chain[g+1] = crc8_byte(chain[g], hdr[8*(HDR_BYTES-g)-1 -: 8], POLY);
   end

   assign hec = chain[HDR_BYTES] ^ COSET;
endmodule

// File: rtl/aal5_segmenter.sv
`timescale 1ns/1ps
module aal5_segmenter #(
   parameter int          PAY_BYTES      = 48,
   parameter int          HDR_BYTES      = 4,
   parameter int          LEN_W          = 16,
   parameter logic [31:0] CRC_POLY       = 32'h04C1_1DB7,
   parameter logic [7:0]  HEC_POLY       = 8'h07,
   parameter logic [7:0]  HEC_COSET      = 8'h55,
   parameter bit          TRANSPARENT_EN = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   output logic                   in_ready,
   input  logic [7:0]             in_data,
   input  logic [LEN_W-1:0]       pkt_len,
   input  logic [8*HDR_BYTES-1:0] hdr_word,
   input  logic [15:0]            ctl_word,
   input  logic [1:0]             mode,
   output logic                   out_valid,
   output logic [7:0]             out_data,
   output logic                   out_sop
);
   import aal5seg_pkg::*;

   localparam int TRL_BYTES = 8;
   localparam int HW        = 8*HDR_BYTES;
   localparam int IDX_W     = $clog2(PAY_BYTES);
   localparam int TRL_POS   = PAY_BYTES - TRL_BYTES;
   localparam int CRC_POS   = PAY_BYTES - 4;
   localparam logic [IDX_W-1:0] IDX_TRL  = IDX_W'(TRL_POS);
   localparam logic [IDX_W-1:0] IDX_CRC  = IDX_W'(CRC_POS);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PAY_BYTES-1);
   localparam logic [IDX_W-1:0] IDX_HEC  = IDX_W'(HDR_BYTES);
   localparam logic [LEN_W-1:0] LIM_AAL5 = LEN_W'(TRL_POS);
   localparam logic [LEN_W-1:0] LIM_TR   = LEN_W'(PAY_BYTES);
   localparam logic [HW-1:0]    PTI_NET  = HW'(8);
   localparam logic [HW-1:0]    PTI_EOP  = HW'(2);

   // elaboration-time parameter checks
   if (PAY_BYTES < TRL_BYTES || (PAY_BYTES % 4) != 0) begin : g_bad_pay
      $error("PAY_BYTES must be a multiple of 4 and hold the trailer");
   end
   if (HDR_BYTES < 1 || HDR_BYTES >= PAY_BYTES) begin : g_bad_hdr
      $error("HDR_BYTES out of range");
   end
   if (LEN_W < 7 || LEN_W > 16) begin : g_bad_len
      $error("LEN_W must lie in 7..16");
   end

   // mode variant: transparent modes may be compiled out
   seg_mode_e mode_in;
   if (TRANSPARENT_EN) begin : g_tr_on
      assign mode_in = seg_mode_e'(mode);
   end else begin : g_tr_off
      assign mode_in = MODE_AAL5;
   end

   seg_state_e       st_q, st_d;
   logic [IDX_W-1:0] idx_q, idx_d;
   logic [LEN_W-1:0] rem_q, rem_d, acc_q, acc_d;
   logic [HW-1:0]    hdr_q;
   logic [15:0]      ctl_q;
   seg_mode_e        mode_q;
   logic             fin_q, fin_d;
   logic             start;

   logic             emit, emit_sop;
   logic [7:0]       emit_byte;
   logic             crc_clr, crc_en;
   logic [31:0]      crc_q;
   logic [HW-1:0]    hdr_eff;
   logic [7:0]       hec, hdr_byte;
   logic [31:0]      trl_word;
   logic             is_aal5, has_data;

   function automatic logic is_last(input logic [LEN_W-1:0] r, input logic aal5);
      return aal5 ? (r <= LIM_AAL5) : (r <= LIM_TR);
   endfunction

   assign is_aal5  = (mode_q == MODE_AAL5);
   assign has_data = (rem_q != '0);
   assign start    = (st_q == ST_IDLE) && in_valid;
   assign in_ready = (st_q == ST_PAY) && has_data;
   assign trl_word = {ctl_q, 16'(acc_q)};
   assign hdr_eff  = (fin_q && (is_aal5 || mode_q == MODE_TR_PTI))
                   ? ((hdr_q & ~PTI_NET) | PTI_EOP) : hdr_q;

   aal5seg_hec #(.HDR_BYTES(HDR_BYTES), .POLY(HEC_POLY), .COSET(HEC_COSET)) u_hec (
      .hdr (hdr_eff),
      .hec (hec)
   );

   aal5seg_crc32 #(.POLY(CRC_POLY), .SEED(32'hFFFF_FFFF)) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (crc_clr),
      .en    (crc_en),
      .din   (emit_byte),
      .crc_q (crc_q)
   );

   always_comb begin
      hdr_byte = 8'h00;
      for (int k = 0; k < HDR_BYTES; k++) begin
         if (idx_q == IDX_W'(k)) hdr_byte = hdr_eff[8*(HDR_BYTES-1-k) +: 8];
      end
   end

   always_comb begin
      st_d      = st_q;
      idx_d     = idx_q;
      rem_d     = rem_q;
      acc_d     = acc_q;
      fin_d     = fin_q;
      emit      = 1'b0;
      emit_sop  = 1'b0;
      emit_byte = 8'h00;
      crc_clr   = 1'b0;
      crc_en    = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (in_valid) begin
               st_d    = ST_HDR;
               idx_d   = '0;
               rem_d   = pkt_len;
               acc_d   = '0;
               fin_d   = is_last(pkt_len, mode_in == MODE_AAL5);
               crc_clr = 1'b1;
            end
         end
         ST_HDR: begin
            emit      = 1'b1;
            emit_sop  = (idx_q == '0);
            emit_byte = (idx_q == IDX_HEC) ? hec : hdr_byte;
            if (idx_q == IDX_HEC) begin
               st_d  = ST_PAY;
               idx_d = '0;
            end else begin
               idx_d = idx_q + 1'b1;
            end
         end
         ST_PAY: begin
            if (has_data) begin
               emit      = in_valid;
               emit_byte = in_data;
               crc_en    = in_valid && is_aal5;
               if (in_valid) begin
                  rem_d = rem_q - 1'b1;
                  acc_d = acc_q + 1'b1;
               end
            end else if (is_aal5 && fin_q && idx_q >= IDX_TRL) begin
               emit = 1'b1;
               if (idx_q < IDX_CRC) begin
                  emit_byte = word_byte(trl_word, idx_q[1:0]);
                  crc_en    = 1'b1;
               end else begin
                  emit_byte = word_byte(~crc_q, idx_q[1:0]);
               end
            end else begin
               emit   = 1'b1;
               crc_en = is_aal5;
            end
            if (emit) begin
               if (idx_q == IDX_LAST) begin
                  idx_d = '0;
                  if (fin_q) begin
                     st_d = ST_IDLE;
                  end else begin
                     st_d  = ST_HDR;
                     fin_d = is_last(rem_d, is_aal5);
                  end
               end else begin
                  idx_d = idx_q + 1'b1;
               end
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         idx_q     <= '0;
         rem_q     <= '0;
         acc_q     <= '0;
         fin_q     <= 1'b0;
         hdr_q     <= '0;
         ctl_q     <= '0;
         mode_q    <= MODE_AAL5;
         out_valid <= 1'b0;
         out_sop   <= 1'b0;
         out_data  <= 8'h00;
      end else begin
         st_q      <= st_d;
         idx_q     <= idx_d;
         rem_q     <= rem_d;
         acc_q     <= acc_d;
         fin_q     <= fin_d;
         out_valid <= emit;
         out_sop   <= emit_sop;
         out_data  <= emit_byte;
         if (start) begin
            hdr_q  <= hdr_word;
            ctl_q  <= ctl_word;
            mode_q <= mode_in;
         end
      end
   end
endmodule

// File: rtl/aal5seg_chk.sv
`timescale 1ns/1ps
module aal5seg_chk #(
   parameter int CELL_BYTES = 53,
   parameter int HDR_LEN    = 5
) (
   input logic       clk,
   input logic       rst_n,
   input logic       in_valid,
   input logic       in_ready,
   input logic [7:0] in_data,
   input logic       out_valid,
   input logic [7:0] out_data,
   input logic       out_sop
);
   logic [7:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt_q <= '0;
      else if (out_valid && out_sop) cnt_q <= 8'd1;
      else if (out_valid)            cnt_q <= cnt_q + 8'd1;
   end

   p_sop_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
      out_sop |-> out_valid);

   p_cell_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_sop) |-> (cnt_q == 8'd0 || cnt_q == 8'(CELL_BYTES)));

   p_cell_body_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_sop) |-> (cnt_q != 8'd0 && cnt_q < 8'(CELL_BYTES)));

   p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_valid && !out_sop && out_data == $past(in_data)));

   p_hdr_noaccept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (out_sop || cnt_q < 8'(HDR_LEN))) |-> !$past(in_ready));
endmodule

bind aal5_segmenter aal5seg_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_data   (in_data),
   .out_valid (out_valid),
   .out_data  (out_data),
   .out_sop   (out_sop)
);

// File: tb/aal5_segmenter_bench.sv
`timescale 1ns/1ps
module aal5_segmenter_bench;

   typedef struct packed {
      logic [1:0]  mode;
      logic [15:0] len;
      logic [7:0]  cells;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{2'b00, 16'd1,   8'd1},
      '{2'b00, 16'd40,  8'd1},
      '{2'b00, 16'd41,  8'd2},
      '{2'b00, 16'd48,  8'd2},
      '{2'b00, 16'd88,  8'd2},
      '{2'b00, 16'd89,  8'd3},
      '{2'b00, 16'd100, 8'd3},
      '{2'b01, 16'd48,  8'd1},
      '{2'b01, 16'd49,  8'd2},
      '{2'b10, 16'd20,  8'd1},
      '{2'b10, 16'd96,  8'd2},
      '{2'b11, 16'd5,   8'd1}
   };
   localparam int CELL = 53;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [7:0]  in_data = 8'h00;
   logic [15:0] pkt_len = 16'd0;
   logic [31:0] hdr_word = 32'h0;
   logic [15:0] ctl_word = 16'h0;
   logic [1:0]  mode = 2'b00;
   logic        out_valid;
   logic [7:0]  out_data;
   logic        out_sop;

   int checks = 0;
   int errors = 0;

   logic [7:0] cap    [0:1023];
   logic       capsop [0:1023];
   int         ncap = 0;
   logic [7:0] exp_b  [0:1023];
   int         exp_r  [0:1023];
   int         exp_n;

   always #2 clk = ~clk;

   aal5_segmenter u_aal5_segmenter (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .pkt_len(pkt_len), .hdr_word(hdr_word),
      .ctl_word(ctl_word), .mode(mode), .out_valid(out_valid),
      .out_data(out_data), .out_sop(out_sop)
   );

   always @(negedge clk) begin
      if (rst_n && out_valid && ncap < 1024) begin
         cap[ncap]    = out_data;
         capsop[ncap] = out_sop;
         ncap++;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, expv);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R1: watchdog actual=hung expected=completion");
      finish_run();
   end

   function automatic logic [31:0] m_crc(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] r;
      r = c;
      for (int b = 7; b >= 0; b--) begin
         logic fb;
         fb = r[31] ^ d[b];
         r  = {r[30:0], 1'b0};
         if (fb) r = r ^ 32'h04C1_1DB7;
      end
      return r;
   endfunction

   function automatic logic [7:0] m_hec(input logic [31:0] h);
      logic [7:0] r;
      r = 8'h00;
      for (int i = 31; i >= 0; i--) begin
         logic fb;
         fb = r[7] ^ h[i];
         r  = {r[6:0], 1'b0};
         if (fb) r = r ^ 8'h07;
      end
      return r ^ 8'h55;
   endfunction

   function automatic logic [7:0] pat(input int i, input int seed);
      return 8'((i * 7 + seed * 29 + 3) & 255);
   endfunction

   // roles: 0 header, 1 data, 2 pad, 3 hec, 4 length word, 5 crc field
   task automatic build_exp(input logic [1:0] md, input int len, input logic [31:0] h,
                            input logic [15:0] c, input int seed, output int ncell);
      logic [7:0] p [0:1023];
      int         pr [0:1023];
      int         plen;
      logic [31:0] crc, tw;
      bit aal5;
      aal5 = (md == 2'b00);
      if (aal5) ncell = (len + 8 + 47) / 48;
      else      ncell = (len == 0) ? 1 : (len + 47) / 48;
      plen = ncell * 48;
      for (int i = 0; i < plen; i++) begin
         p[i]  = (i < len) ? pat(i, seed) : 8'h00;
         pr[i] = (i < len) ? 1 : 2;
      end
      if (aal5) begin
         tw = {c, 16'(len)};
         for (int k = 0; k < 4; k++) begin
            p[plen-8+k]  = tw[31-8*k -: 8];
            pr[plen-8+k] = 4;
         end
         crc = 32'hFFFF_FFFF;
         for (int i = 0; i < plen - 4; i++) crc = m_crc(crc, p[i]);
         crc = ~crc;
         for (int k = 0; k < 4; k++) begin
            p[plen-4+k]  = crc[31-8*k -: 8];
            pr[plen-4+k] = 5;
         end
      end
      exp_n = 0;
      for (int cl = 0; cl < ncell; cl++) begin
         logic [31:0] hh;
         hh = h;
         if (cl == ncell - 1 && (md == 2'b00 || md == 2'b10)) hh = (h & ~32'h8) | 32'h2;
         for (int k = 0; k < 4; k++) begin
            exp_b[exp_n] = hh[31-8*k -: 8]; exp_r[exp_n] = 0; exp_n++;
         end
         exp_b[exp_n] = m_hec(hh); exp_r[exp_n] = 3; exp_n++;
         for (int i = 0; i < 48; i++) begin
            exp_b[exp_n] = p[cl*48+i]; exp_r[exp_n] = pr[cl*48+i]; exp_n++;
         end
      end
   endtask

   task automatic run_pkt(input logic [1:0] md, input int len, input int cells,
                          input int seed, input bit perturb);
      logic [31:0] h;
      logic [15:0] c;
      int ncell, i, g, to, mism;
      bit ready_late;
      int mc [6];
      int fa [6];
      int fe [6];
      string lbl;
      h = 32'h05A3_C7E8 + 32'(seed) * 32'h0001_0100;
      c = 16'h5A00 + 16'(seed);
      build_exp(md, len, h, c, seed, ncell);
      @(negedge clk);
      ncap     = 0;
      hdr_word = h;
      ctl_word = c;
      mode     = md;
      pkt_len  = 16'(len);
      i = 0;
      g = 0;
      to = 0;
      while (i < len && to < 5000) begin
         @(negedge clk);
         to++;
         if (perturb && i == 1) begin
            hdr_word = 32'hFFFF_FFF5;
            ctl_word = 16'h1234;
            mode     = 2'b01;
            pkt_len  = 16'd3;
         end
         g++;
         if ((g % 5) == 4) begin
            in_valid = 1'b0;
         end else begin
            in_valid = 1'b1;
            in_data  = pat(i, seed);
            if (in_ready) i++;
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      ready_late = 1'b0;
      to = 0;
      while (ncap < exp_n && to < 2000) begin
         @(negedge clk);
         to++;
         if (in_ready) ready_late = 1'b1;
      end
      repeat (8) begin
         @(negedge clk);
         if (in_ready) ready_late = 1'b1;
      end
      // R3: no acceptance after the packet's data is taken
      check(!ready_late, "R3 in_ready after data", int'(ready_late), 0);
      if (md != 2'b00) lbl = "R9 cell count";
      else if (cells > (len + 47) / 48) lbl = "R6 cell count";
      else lbl = "R4 cell count";
      check(ncap == cells * CELL && ncap == exp_n, lbl, ncap, cells * CELL);
      mism = 0;
      for (int k = 0; k < ncap && k < exp_n; k++)
         if (capsop[k] != ((k % CELL) == 0)) mism++;
      check(mism == 0, "R1 sop position", mism, 0);
      for (int r = 0; r < 6; r++) begin mc[r] = 0; fa[r] = 0; fe[r] = 0; end
      for (int k = 0; k < ncap && k < exp_n; k++) begin
         if (cap[k] != exp_b[k]) begin
            if (mc[exp_r[k]] == 0) begin fa[exp_r[k]] = cap[k]; fe[exp_r[k]] = exp_b[k]; end
            mc[exp_r[k]]++;
         end
      end
      if (perturb) begin
         mism = 0;
         for (int r = 0; r < 6; r++) mism += mc[r];
         check(mism == 0 && ncap == exp_n, "R11 sampled at start", mism, 0);
      end
      check(mc[0] == 0, "R7 header", fa[0], fe[0]);
      check(mc[3] == 0, "R2 hec", fa[3], fe[3]);
      if (len > 0) check(mc[1] == 0, "R3 data order", fa[1], fe[1]);
      check(mc[2] == 0, (md == 2'b00) ? "R4 padding" : "R9 padding", fa[2], fe[2]);
      if (md == 2'b00) begin
         check(mc[4] == 0, "R8 control length word", fa[4], fe[4]);
         check(mc[5] == 0, "R5 crc field", fa[5], fe[5]);
      end
   endtask

   initial begin
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R10: reset state
      check(!out_valid && !out_sop && !in_ready, "R10 during reset",
            {out_valid, out_sop, in_ready}, 0);
      rst_n = 1'b1;
      repeat (6) @(negedge clk);
      check(!out_valid && !out_sop && !in_ready, "R10 idle after reset",
            {out_valid, out_sop, in_ready}, 0);
      for (int v = 0; v < NV; v++)
         run_pkt(VECS[v].mode, int'(VECS[v].len), int'(VECS[v].cells), v + 1, 1'b0);
      // R11: inputs changed after start must not alter the packet
      run_pkt(2'b00, 100, 3, 40, 1'b1);
      // back-to-back: a short AAL5 packet right after a transparent one
      run_pkt(2'b01, 1, 1, 41, 1'b0);
      run_pkt(2'b00, 2, 1, 42, 1'b0);
      finish_run();
   end

endmodule